// File: doc/BRIEF.md
# DTMF Guard-Time Steering and Code Latch

This block sits behind a tone classifier. It takes a level flag that says a valid tone pair is being heard, and the 4-bit code of that pair. It decides whether the pair has lasted long enough to count as a key press, and whether a later silence has lasted long enough to count as a gap between keys. A saturating up/down integrator, clocked by a millisecond-scale tick, does the job an analogue RC network would otherwise do. It has one guard length for tone presence and a separate one for tone absence.

When presence is confirmed, the code is captured into an output register. A delayed-steering flag follows a fixed number of clock cycles later, so the captured data is stable before the flag is seen. The flag stays high through short dropouts. It falls only once absence has been confirmed, and the captured code stays in place until the next accepted pair. An inhibit input keeps the four letter keys from being accepted. An output enable gates the data bus. Power-down freezes every timer.

The flag and code are plain levels with no handshake. A consumer reads the code while the delayed flag is high, and there is no back-pressure.

Top module: `dtmf_steer_latch`

## Requirements
- R1: After reset the held code is 0000, the delayed flag is low and the integrator is empty.
- R2: A pair is accepted only if the tone flag stays high for PRESENT_TICKS ticks; a flag held for PRESENT_TICKS-1 ticks is not accepted.
- R3: Once a pair is accepted, the integrator is refilled to ABSENT_TICKS on every tick that the flag is high. The dropout tolerance after a long tone is therefore the same as after a short one.
- R4: A dropout shorter than ABSENT_TICKS ticks leaves the held code and the delayed flag unchanged, and the flag does not pulse.
- R5: The delayed flag falls exactly on the ABSENT_TICKS-th consecutive tick with the tone flag low. The held code stays unchanged after the fall.
- R6: The held code is updated on the accepting clock edge, and the delayed flag rises exactly SETTLE_CLKS clock cycles later.
- R7: While letters_block is high, the letter codes 1101, 1110, 1111 and 0000 are never accepted and the previous code is kept. With it low they are accepted like any digit. Other codes, such as 1100, are accepted regardless of letters_block.
- R8: With out_en low, code_valid is low and code_out reads 0000. With out_en high, code_valid is high and code_out shows the held code.
- R9: While pwr_down is high, the tick, the integrator and the settle timer do not advance. Tone activity neither accepts nor releases a pair.
- R10: Before acceptance, the integrator counts down one step per tick with the flag low and saturates at zero. Two bursts with a short gap can therefore add up to an acceptance, while two bursts with a long gap cannot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | High freezes all timing |
| tone_seen | input | 1 | Level flag from the classifier: a valid pair is present |
| tone_code | input | 4 | Code of the present pair |
| letters_block | input | 1 | High blocks acceptance of the four letter codes |
| out_en | input | 1 | Output enable for the data bus |
| code_out | output | 4 | Held code when enabled, else 0000 |
| code_valid | output | 1 | High when code_out is driven (stands for a tri-state bus) |
| steer_done | output | 1 | Delayed-steering flag |

## Verification
The held code changes on the clock edge of the tick that completes PRESENT_TICKS flag-high ticks. steer_done rises SETTLE_CLKS cycles after that edge and falls on the edge of the ABSENT_TICKS-th flag-low tick. code_out and code_valid follow out_en within the same cycle. The bench changes inputs on falling edges and holds each level for a whole number of tick periods, so the number of ticks in every window is exact. It samples a few cycles after the edge where a result is due, and a monitor measures the exact gap between a code change and the rise of steer_done.

// File: rtl/dtmf_steer_pkg.sv
`timescale 1ns/1ps
package dtmf_steer_pkg;
  typedef logic [3:0] code_t;

  // letter keys: the four codes blocked by the inhibit input
  function automatic logic is_letter(input code_t c);
    return (c == 4'hD) || (c == 4'hE) || (c == 4'hF) || (c == 4'h0);
  endfunction
endpackage

// File: rtl/steer_tick_gen.sv
`timescale 1ns/1ps
module steer_tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = !halt;
    end else begin : g_count
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (!halt)      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end
      assign tick = !halt && (div_q == LAST);

      a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(div_q));
    end
  endgenerate
endmodule

// File: rtl/steer_integrator.sv
`timescale 1ns/1ps
module steer_integrator #(
  parameter int unsigned PRESENT_TICKS = 30,
  parameter int unsigned ABSENT_TICKS  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic tick,
  input  logic flag,
  output logic accept,
  output logic release_o,
  output logic steered
);
  localparam int unsigned MAXV = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int unsigned CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] P_LAST = CW'(PRESENT_TICKS - 1);
  localparam logic [CW-1:0] FULL   = CW'(ABSENT_TICKS);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] lvl_q;
  logic          st_q;
  logic          step;

  assign step      = tick && !halt;
  assign accept    = step && !st_q && flag && (lvl_q == P_LAST);
  assign release_o = step && st_q && !flag && (lvl_q == ONE);
  assign steered   = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      st_q  <= 1'b0;
    end else if (step) begin
      if (!st_q) begin
        if (flag) begin
          if (lvl_q == P_LAST) begin
            st_q  <= 1'b1;
            lvl_q <= FULL;
          end else begin
            lvl_q <= lvl_q + 1'b1;
          end
        end else if (lvl_q != '0) begin
          lvl_q <= lvl_q - 1'b1;
        end
      end else begin
        if (flag) begin
          lvl_q <= FULL;
        end else if (lvl_q == ONE) begin
          st_q  <= 1'b0;
          lvl_q <= '0;
        end else begin
          lvl_q <= lvl_q - 1'b1;
        end
      end
    end
  end

  a_r3_refill_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q && step && flag) |=> (lvl_q == FULL));
  a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL || (!st_q && lvl_q <= P_LAST));
  a_r9_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> ($stable(lvl_q) && $stable(st_q)));
  a_r2_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> st_q);
endmodule

// File: rtl/steer_code_latch.sv
`timescale 1ns/1ps
module steer_code_latch
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned SETTLE_CLKS = 250
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  halt,
  input  logic  capture,
  input  logic  drop,
  input  code_t code_in,
  output code_t code_q,
  output logic  flag_q
);
  localparam int unsigned SW = $clog2(SETTLE_CLKS + 1);
  localparam logic [SW-1:0] SET_V = SW'(SETTLE_CLKS);

  logic [SW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      flag_q <= 1'b0;
      wait_q <= '0;
    end else if (capture) begin
      code_q <= code_in;
      wait_q <= SET_V;
    end else if (drop) begin
      flag_q <= 1'b0;
      wait_q <= '0;
    end else if (!halt && wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      if (wait_q == SW'(1)) flag_q <= 1'b1;
    end
  end

  a_r6_data_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $stable(code_q));
  a_r5_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(code_q));
  initial a_r6_settle_nonzero: assert (SETTLE_CLKS >= 1);
endmodule

// File: rtl/dtmf_steer_latch.sv
`timescale 1ns/1ps
module dtmf_steer_latch
  import dtmf_steer_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 50000,
  parameter int unsigned PRESENT_TICKS = 30,
  parameter int unsigned ABSENT_TICKS  = 30,
  parameter int unsigned SETTLE_CLKS   = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       tone_seen,
  input  logic [3:0] tone_code,
  input  logic       letters_block,
  input  logic       out_en,
  output logic [3:0] code_out,
  output logic       code_valid,
  output logic       steer_done
);
  logic  tick;
  logic  flag_eff;
  logic  accept;
  logic  rel;
  logic  steered;
  code_t held;

  // a blocked letter looks like silence to the integrator
  assign flag_eff = tone_seen && !(letters_block && is_letter(tone_code));

  steer_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .halt(pwr_down), .tick(tick)
  );

  steer_integrator #(
    .PRESENT_TICKS(PRESENT_TICKS), .ABSENT_TICKS(ABSENT_TICKS)
  ) u_integ (
    .clk(clk), .rst_n(rst_n), .halt(pwr_down), .tick(tick), .flag(flag_eff),
    .accept(accept), .release_o(rel), .steered(steered)
  );

  steer_code_latch #(.SETTLE_CLKS(SETTLE_CLKS)) u_latch (
    .clk(clk), .rst_n(rst_n), .halt(pwr_down), .capture(accept), .drop(rel),
    .code_in(tone_code), .code_q(held), .flag_q(steer_done)
  );

  assign code_valid = out_en;
  assign code_out   = out_en ? held : 4'h0;

  a_r7_no_letter_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (letters_block && is_letter(tone_code)) |-> !accept);
  a_r4_flag_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
    steer_done |-> steered);
endmodule

// File: tb/tb_dtmf_steer_latch.sv
`timescale 1ns/1ps
module tb_dtmf_steer_latch;
  localparam int DIV = 4;
  localparam int PT  = 30;
  localparam int AT  = 30;
  localparam int ST  = 3;
  localparam int NV  = 10;
  // {code[17:14], inhibit[13], on_ticks[12:5], accepted[4], expected_code[3:0]}
  localparam logic [17:0] VEC [NV] = '{
    {4'h5, 1'b0, 8'd40, 1'b1, 4'h5},
    {4'h9, 1'b0, 8'd20, 1'b0, 4'h5},
    {4'hD, 1'b1, 8'd40, 1'b0, 4'h5},
    {4'hD, 1'b0, 8'd40, 1'b1, 4'hD},
    {4'h0, 1'b1, 8'd40, 1'b0, 4'hD},
    {4'hE, 1'b1, 8'd40, 1'b0, 4'hD},
    {4'hC, 1'b1, 8'd40, 1'b1, 4'hC},
    {4'h0, 1'b0, 8'd40, 1'b1, 4'h0},
    {4'h3, 1'b0, 8'd29, 1'b0, 4'h0},
    {4'h3, 1'b0, 8'd30, 1'b1, 4'h3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic tone_seen = 1'b0;
  logic [3:0] tone_code = 4'h0;
  logic letters_block = 1'b0;
  logic out_en = 1'b1;
  logic [3:0] code_out;
  logic code_valid;
  logic steer_done;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dtmf_steer_latch #(
    .CLKS_PER_TICK(DIV), .PRESENT_TICKS(PT), .ABSENT_TICKS(AT), .SETTLE_CLKS(ST)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tone_seen(tone_seen),
    .tone_code(tone_code), .letters_block(letters_block), .out_en(out_en),
    .code_out(code_out), .code_valid(code_valid), .steer_done(steer_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  // R6 monitor: gap between a code change and the rise of steer_done
  int since = 1000;
  logic [3:0] prev_code = 4'h0;
  logic prev_flag = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (code_out != prev_code) since = 0;
      else if (since < 1000) since++;
      if (steer_done && !prev_flag && since < 100)
        chk(since == ST, "R6 settle gap", since, ST);
    end
    prev_code = code_out;
    prev_flag = steer_done;
  end

  // R4 monitor: count falls of steer_done
  int falls = 0;
  always @(negedge clk) if (prev_flag && !steer_done) falls++;

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(code_out == 4'h0, "R1 reset code", code_out, 0);
    chk(steer_done == 1'b0, "R1 reset flag", steer_done, 0);

    // table walk: R2 R7
    for (int i = 0; i < NV; i++) begin
      tone_code = VEC[i][17:14];
      letters_block = VEC[i][13];
      tone_seen = 1'b1;
      wait_ticks(int'(VEC[i][12:5]));
      tone_seen = 1'b0;
      repeat (4) @(negedge clk);
      chk(steer_done == VEC[i][4], "R2/R7 accept", steer_done, VEC[i][4]);
      chk(code_out == VEC[i][3:0], "R7 code after tone", code_out, VEC[i][3:0]);
      wait_ticks(AT + 10);
      letters_block = 1'b0;
      chk(steer_done == 1'b0, "R5 released", steer_done, 0);
      chk(code_out == VEC[i][3:0], "R5 code kept", code_out, VEC[i][3:0]);
    end

    // R5 exact release tick
    tone_code = 4'h2; tone_seen = 1'b1;
    wait_ticks(40);
    tone_seen = 1'b0;
    wait_ticks(AT - 1);
    chk(steer_done == 1'b1, "R5 held one tick short", steer_done, 1);
    wait_ticks(1);
    chk(steer_done == 1'b0, "R5 fall on last absent tick", steer_done, 0);
    chk(code_out == 4'h2, "R5 code after fall", code_out, 2);

    // R3 R4 long tone with dropouts
    tone_code = 4'h4; tone_seen = 1'b1;
    wait_ticks(100);
    falls = 0;
    tone_seen = 1'b0;
    wait_ticks(20);
    chk(steer_done == 1'b1 && code_out == 4'h4, "R4 short dropout", steer_done, 1);
    tone_seen = 1'b1; wait_ticks(5);
    tone_seen = 1'b0; wait_ticks(AT - 1);
    chk(steer_done == 1'b1, "R3 refill after dropout", steer_done, 1);
    chk(falls == 0, "R4 no flag pulse", falls, 0);
    wait_ticks(10);
    chk(steer_done == 1'b0, "R5 release after long tone", steer_done, 0);

    // R10 burst accumulation
    tone_code = 4'h8;
    tone_seen = 1'b1; wait_ticks(20);
    tone_seen = 1'b0; wait_ticks(20);
    tone_seen = 1'b1; wait_ticks(20);
    tone_seen = 1'b0; repeat (4) @(negedge clk);
    chk(steer_done == 1'b0 && code_out == 4'h4, "R10 long gap drains", code_out, 4);
    wait_ticks(40);
    tone_code = 4'h6;
    tone_seen = 1'b1; wait_ticks(20);
    tone_seen = 1'b0; wait_ticks(4);
    tone_seen = 1'b1; wait_ticks(20);
    tone_seen = 1'b0; repeat (4) @(negedge clk);
    chk(steer_done == 1'b1 && code_out == 4'h6, "R10 short gap adds up", code_out, 6);
    wait_ticks(40);

    // R9 power-down
    pwr_down = 1'b1; tone_code = 4'h7; tone_seen = 1'b1;
    wait_ticks(60);
    tone_seen = 1'b0; pwr_down = 1'b0;
    repeat (4) @(negedge clk);
    chk(steer_done == 1'b0 && code_out == 4'h6, "R9 no accept while down", code_out, 6);
    tone_seen = 1'b1; wait_ticks(40);
    pwr_down = 1'b1; tone_seen = 1'b0;
    wait_ticks(60);
    chk(steer_done == 1'b1 && code_out == 4'h7, "R9 no release while down", steer_done, 1);
    pwr_down = 1'b0;
    wait_ticks(40);
    chk(steer_done == 1'b0, "R9 release after wake", steer_done, 0);

    // R8 output enable
    out_en = 1'b0; @(negedge clk);
    chk(code_valid == 1'b0 && code_out == 4'h0, "R8 disabled", code_out, 0);
    out_en = 1'b1; @(negedge clk);
    chk(code_valid == 1'b1 && code_out == 4'h7, "R8 enabled", code_out, 7);

    // R1 mid-run reset
    rst_n = 1'b0; @(negedge clk);
    chk(code_out == 4'h0 && steer_done == 1'b0, "R1 reset again", code_out, 0);
    rst_n = 1'b1; @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule